// File: doc/BRIEF.md
# Two-Operand Instruction Phase Sequencer

This block is the control sequencer of a small 16-bit processor core. It takes an instruction word with one source and one destination operand and walks it through fetch, decode, source operand fetch, destination operand fetch, execute and store. Any phase the instruction does not need is skipped, so register-only work finishes in one cycle and a memory-to-memory operation takes six. Decode and execute do not get cycles of their own. Decode is folded into the fetch cycle. Execute is folded into the last operand cycle.

The sequencer decodes the source and destination addressing modes. It resolves the special meanings of the program counter, stack pointer, status register and constant register. It drives one shared memory port for instruction words, extension words, operand reads and result write-back. The arithmetic itself is external. The sequencer presents both operands and an operation code on an execute strobe, and takes the result back in the same cycle.

At the end of every instruction the block pulses `done` for one cycle. Alongside the pulse it reports how many cycles the instruction used. The memory array and the ALU are modelled outside the block.

Top module: `opseq_core`

## Requirements
- R1: The instruction word uses these fields:
  - [15:12] operation; values 0010 and 0011 are jumps, all other values are two-operand instructions.
  - [11:8] source register.
  - [7] destination mode: 0 register, 1 indexed.
  - [6] byte flag.
  - [5:4] source mode: 00 register, 01 indexed, 10 indirect, 11 autoincrement.
  - [3:0] destination register.
  - Register 0 is the program counter, 1 the stack pointer, 2 the status register and 3 the constant register.
- R2: While reset is held and in the first cycle after it, the block fetches from address RESET_PC and `done` is low.
- R3: Each instruction ends with `done` high for one cycle, in the cycle after its last cycle. `done_cycles` then carries the instruction's cycle count. A register-to-register instruction costs 1 cycle.
- R4: An indirect, autoincrement or immediate source adds one cycle, which performs the operand read.
- R5: An indexed, absolute or symbolic source adds two cycles: one extension-word read, then one operand read. The effective address is the extension word plus the base. The base is the register's value, or 0 for the status register, or the address of the extension word for the program counter.
- R6: An indexed, absolute or symbolic destination adds two cycles (extension word, operand read) plus one write-back cycle. The ALU result is written to the effective address, which is formed as in R5.
- R7: The constant register in source modes 00, 01, 10 and 11 yields 0x0000, 0x0001, 0x0002 and 0xFFFF. The status register in modes 10 and 11 yields 0x0004 and 0x0008. None of the six costs a cycle or touches memory.
- R8: Autoincrement adds 2 for word operations and 1 for byte operations. It always adds 2 to the stack pointer and to the program counter, so autoincrement on the program counter reads an immediate word.
- R9: When the autoincrement update and the destination register write target the same register in the same cycle, the destination write wins. This holds for the program counter too, so a move to it branches.
- R10: A jump costs 2 cycles. The new program counter is the address after the jump word plus twice the signed 10-bit offset in bits [9:0].
- R11: Byte and word forms of an instruction take the same number of cycles.
- R12: The memory port issues at most one access per cycle. It writes only in the store cycle of an instruction with a memory destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data for the current address, same cycle |
| alu_go | output | 1 | Execute strobe, operands valid |
| alu_op | output | 4 | Operation field of the current instruction |
| alu_src | output | 16 | Source operand |
| alu_dst | output | 16 | Destination operand |
| alu_res | input | 16 | ALU result for the presented operands, same cycle |
| done | output | 1 | One-cycle end-of-instruction pulse |
| done_cycles | output | 3 | Cycle count of the instruction just ended |

## Verification
Two updates can land on one register in a single cycle. One is the autoincrement write-back of the source register during the operand read. The other is the destination register write of the same instruction, or the program counter's own advance past an immediate word.

The bench provokes the first case by moving through a register into that same register with autoincrement. It judges the outcome by storing the register to memory and expecting the loaded word, not the incremented pointer.

The program counter case is provoked by moving an immediate into it, with a one-word trap instruction placed right after the immediate. The branch is judged correct when the next instruction's cycle count matches the instruction at the target. A further check confirms that the trap never altered the register it targets.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int DW    = 16;  // data and address width
    localparam int RW    = 4;   // register index width
    localparam int CNT_W = 3;   // cycle count width (max cost 6)

    localparam logic [RW-1:0] REG_PC = 4'd0;
    localparam logic [RW-1:0] REG_SP = 4'd1;
    localparam logic [RW-1:0] REG_SR = 4'd2;
    localparam logic [RW-1:0] REG_CG = 4'd3;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_SRC_EXT,
        PH_SRC_RD,
        PH_DST_EXT,
        PH_DST_RD,
        PH_STORE,
        PH_JUMP
    } phase_e;

    typedef enum logic [2:0] {
        SK_REG,
        SK_CONST,
        SK_IND,
        SK_INC,
        SK_IDX
    } src_kind_e;

    typedef struct packed {
        phase_e           ph;
        logic [DW-1:0]    pc;
        logic [DW-1:0]    ir;
        logic [DW-1:0]    sadr;
        logic [DW-1:0]    dadr;
        logic [DW-1:0]    src;
        logic [DW-1:0]    res;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cyc;
        logic             done;
    } seq_t;

    // R7: hardwired operand values of the constant and status registers
    function automatic logic [DW-1:0] cg_value(input logic [RW-1:0] r, input logic [1:0] m);
        logic [DW-1:0] v;
        if (r == REG_CG) begin
            case (m)
                2'b00:   v = 16'h0000;
                2'b01:   v = 16'h0001;
                2'b10:   v = 16'h0002;
                default: v = 16'hFFFF;
            endcase
        end else begin
            v = m[0] ? 16'h0008 : 16'h0004;
        end
        return v;
    endfunction

endpackage

// File: rtl/opseq_decode.sv
module opseq_decode
    import opseq_pkg::*;
(
    input  logic [DW-1:0] ir,
    output logic          is_jump,
    output src_kind_e     src_kind,
    output logic [RW-1:0] src_reg,
    output logic [RW-1:0] dst_reg,
    output logic          dst_mem,
    output logic [1:0]    inc_step,
    output logic [DW-1:0] const_val,
    output logic [9:0]    jmp_off,
    output logic [3:0]    op
);

    logic [1:0] smode;
    logic       byte_op;

    // R1: field positions
    always_comb begin
        op       = ir[15:12];
        src_reg  = ir[11:8];
        dst_mem  = ir[7];
        byte_op  = ir[6];
        smode    = ir[5:4];
        dst_reg  = ir[3:0];
        jmp_off  = ir[9:0];
        is_jump  = (ir[15:13] == 3'b001);

        if (src_reg == REG_CG || (src_reg == REG_SR && smode[1])) begin
            src_kind = SK_CONST;
        end else begin
            case (smode)
                2'b00:   src_kind = SK_REG;
                2'b01:   src_kind = SK_IDX;
                2'b10:   src_kind = SK_IND;
                default: src_kind = SK_INC;
            endcase
        end
        const_val = cg_value(src_reg, smode);

        // R8: byte step 1 except on stack pointer and program counter
        inc_step = (byte_op && src_reg != REG_SP && src_reg != REG_PC) ? 2'd1 : 2'd2;
    end

endmodule

// File: rtl/opseq_regfile.sv
module opseq_regfile
    import opseq_pkg::*;
#(
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data
);

    logic [NREG*DW-1:0] flat;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] r_d, r_q;

        // R9: port b (destination write) has priority over port a
        always_comb begin
            r_d = r_q;
            if (wa_en && wa_addr == AW'(i)) r_d = wa_data;
            if (wb_en && wb_addr == AW'(i)) r_d = wb_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign flat[i*DW +: DW] = r_q;
    end

    assign ra_data = flat[ra_addr*DW +: DW];
    assign rb_data = flat[rb_addr*DW +: DW];

endmodule

// File: rtl/opseq_core.sv
module opseq_core
    import opseq_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             alu_go,
    output logic [3:0]       alu_op,
    output logic [DW-1:0]    alu_src,
    output logic [DW-1:0]    alu_dst,
    input  logic [DW-1:0]    alu_res,
    output logic             done,
    output logic [CNT_W-1:0] done_cycles
);

    localparam int NREG = 1 << RW;

    seq_t s_d, s_q;

    logic [DW-1:0] ir_cur, rf_a, rf_b, src_rv, dst_rv, base, pc_rd;
    logic [CNT_W-1:0] cnt_this;
    logic          is_jump, dst_mem, fin, exec_reg;
    src_kind_e     src_kind;
    logic [RW-1:0] src_reg, dst_reg;
    logic [1:0]    inc_step;
    logic [DW-1:0] const_val;
    logic [9:0]    jmp_off;
    logic          wa_en, wb_en;
    logic [DW-1:0] wa_data, wb_data;

    assign ir_cur = (s_q.ph == PH_FETCH) ? mem_rdata : s_q.ir;

    opseq_decode dec_i (
        .ir        (ir_cur),
        .is_jump   (is_jump),
        .src_kind  (src_kind),
        .src_reg   (src_reg),
        .dst_reg   (dst_reg),
        .dst_mem   (dst_mem),
        .inc_step  (inc_step),
        .const_val (const_val),
        .jmp_off   (jmp_off),
        .op        (alu_op)
    );

    opseq_regfile #(.NREG(NREG)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (src_reg),
        .ra_data (rf_a),
        .rb_addr (dst_reg),
        .rb_data (rf_b),
        .wa_en   (wa_en),
        .wa_addr (src_reg),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (dst_reg),
        .wb_data (wb_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.pc;
        mem_wdata = s_q.res;
        alu_go    = 1'b0;
        alu_src   = s_q.src;
        alu_dst   = rf_b;
        wa_en     = 1'b0;
        wa_data   = rf_a + {{(DW-2){1'b0}}, inc_step};
        wb_en     = 1'b0;
        wb_data   = alu_res;
        fin       = 1'b0;
        exec_reg  = 1'b0;
        base      = '0;

        pc_rd    = (s_q.ph == PH_FETCH) ? s_q.pc + 16'd2 : s_q.pc;
        src_rv   = (src_reg == REG_PC) ? pc_rd : rf_a;
        dst_rv   = (dst_reg == REG_PC) ? pc_rd : rf_b;
        cnt_this = (s_q.ph == PH_FETCH) ? CNT_W'(1) : s_q.cnt + CNT_W'(1);
        s_d.cnt  = cnt_this;

        case (s_q.ph)
            PH_FETCH: begin
                mem_req  = 1'b1;
                s_d.ir   = mem_rdata;
                s_d.pc   = s_q.pc + 16'd2;
                if (is_jump) begin
                    s_d.ph = PH_JUMP;
                end else if (src_kind == SK_IDX) begin
                    s_d.ph = PH_SRC_EXT;
                end else if (src_kind == SK_IND || src_kind == SK_INC) begin
                    s_d.ph = PH_SRC_RD;
                end else begin
                    s_d.src = (src_kind == SK_CONST) ? const_val : src_rv;
                    if (dst_mem) begin
                        s_d.ph = PH_DST_EXT;
                    end else begin
                        alu_go   = 1'b1;
                        alu_src  = s_d.src;
                        alu_dst  = dst_rv;
                        exec_reg = 1'b1;
                        fin      = 1'b1;
                    end
                end
            end
            PH_SRC_EXT: begin
                mem_req = 1'b1;
                s_d.pc  = s_q.pc + 16'd2;
                if (src_reg == REG_PC)      base = s_q.pc;
                else if (src_reg == REG_SR) base = '0;
                else                        base = rf_a;
                s_d.sadr = base + mem_rdata;
                s_d.ph   = PH_SRC_RD;
            end
            PH_SRC_RD: begin
                mem_req  = 1'b1;
                mem_addr = (src_kind == SK_IDX) ? s_q.sadr : src_rv;
                s_d.src  = mem_rdata;
                if (src_kind == SK_INC) begin
                    if (src_reg == REG_PC) s_d.pc = s_q.pc + 16'd2;
                    else                   wa_en  = 1'b1;
                end
                if (dst_mem) begin
                    s_d.ph = PH_DST_EXT;
                end else begin
                    alu_go   = 1'b1;
                    alu_src  = mem_rdata;
                    alu_dst  = dst_rv;
                    exec_reg = 1'b1;
                    fin      = 1'b1;
                end
            end
            PH_DST_EXT: begin
                mem_req = 1'b1;
                s_d.pc  = s_q.pc + 16'd2;
                if (dst_reg == REG_PC)      base = s_q.pc;
                else if (dst_reg == REG_SR) base = '0;
                else                        base = rf_b;
                s_d.dadr = base + mem_rdata;
                s_d.ph   = PH_DST_RD;
            end
            PH_DST_RD: begin
                mem_req  = 1'b1;
                mem_addr = s_q.dadr;
                alu_go   = 1'b1;
                alu_src  = s_q.src;
                alu_dst  = mem_rdata;
                s_d.res  = alu_res;
                s_d.ph   = PH_STORE;
            end
            PH_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.dadr;
                fin      = 1'b1;
            end
            PH_JUMP: begin
                s_d.pc = s_q.pc + {{5{jmp_off[9]}}, jmp_off, 1'b0};
                fin    = 1'b1;
            end
            default: s_d.ph = PH_FETCH;
        endcase

        // R9: destination write is applied last and therefore wins
        if (exec_reg) begin
            if (dst_reg == REG_PC) s_d.pc = alu_res;
            else                   wb_en  = 1'b1;
        end

        if (fin) begin
            s_d.done = 1'b1;
            s_d.cyc  = cnt_this;
            s_d.ph   = PH_FETCH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_FETCH;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign done        = s_q.done;
    assign done_cycles = s_q.cyc;

endmodule

// File: rtl/opseq_core_chk.sv
module opseq_core_chk
    import opseq_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [DW-1:0]    mem_addr,
    input logic             done,
    input logic [CNT_W-1:0] done_cycles
);

    p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_req && !mem_we && mem_addr == RESET_PC && !done));

    p_cycle_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_cycles != '0 && done_cycles <= CNT_W'(6)));

    p_write_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (done && done_cycles >= CNT_W'(4)));

    p_write_is_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    p_single_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind opseq_core opseq_core_chk #(.RESET_PC(RESET_PC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .done        (done),
    .done_cycles (done_cycles)
);

// File: tb/opseq_core_tb_top.sv
`timescale 1ns/1ps
module opseq_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, alu_go, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_src, alu_dst, alu_res;
    logic [3:0]  alu_op;
    logic [2:0]  done_cycles;

    logic [15:0] mem [256];
    logic        ld_en = 1'b0;
    logic [15:0] ld_addr = '0, ld_data = '0;
    int          total = 0, bad = 0, ep = 0, wr_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    opseq_core #(.RESET_PC(16'h0000)) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alu_go(alu_go), .alu_op(alu_op), .alu_src(alu_src), .alu_dst(alu_dst),
        .alu_res(alu_res), .done(done), .done_cycles(done_cycles)
    );

    // memory and ALU models: 0101 adds, everything else moves
    assign mem_rdata = mem[mem_addr[8:1]];
    assign alu_res   = (alu_op == 4'h5) ? alu_src + alu_dst : alu_src;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr[8:1]] <= ld_data;
        else if (mem_req && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        if (rst_n && mem_we) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] w);
        ld_en = 1'b1; ld_addr = a; ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic emit(input logic [15:0] w);
        poke(16'(ep * 2), w);
        ep++;
    endtask

    task automatic step(input int exp, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 100);
        chk(done && int'(done_cycles) == exp, {tag, " cycles"}, int'(done_cycles), exp);
    endtask

    task automatic memchk(input logic [15:0] a, input logic [15:0] exp, input string tag);
        chk(mem[a[8:1]] == exp, tag, int'(mem[a[8:1]]), int'(exp));
    endtask

    task automatic build_program();
        logic [15:0] t;
        poke(16'h0120, 16'h0011); poke(16'h0122, 16'h00AB); poke(16'h0130, 16'h5555);
        poke(16'h0142, 16'h5A5A); poke(16'h0144, 16'h7777); poke(16'h0146, 16'hBEEF);
        poke(16'h0160, 16'h3333); poke(16'h0112, 16'hAAAA);
        poke(16'h0150, 16'h0000); poke(16'h0152, 16'h0000);
        for (int k = 0; k < 6; k++) poke(16'(16'h0170 + 2 * k), 16'hAAAA);
        emit(16'h4035); emit(16'h1234);            // mov #1234,r5
        emit(16'h4582); emit(16'h0100);            // mov r5,&0100
        emit(16'h4036); emit(16'h0120);            // mov #0120,r6
        emit(16'h5635);                            // add @r6+,r5
        emit(16'h4682); emit(16'h0102);            // mov r6,&0102
        emit(16'h4677);                            // mov.b @r6+,r7
        emit(16'h4682); emit(16'h0104);            // mov r6,&0104
        emit(16'h4782); emit(16'h0106);            // mov r7,&0106
        emit(16'h450A);                            // mov r5,r10
        emit(16'h4A82); emit(16'h0116);            // mov r10,&0116
        emit(16'h4031); emit(16'h0130);            // mov #0130,r1
        emit(16'h4178);                            // mov.b @r1+,r8
        emit(16'h4182); emit(16'h0108);            // mov r1,&0108
        emit(16'h4382); emit(16'h0170);            // constants
        emit(16'h4392); emit(16'h0172);
        emit(16'h43A2); emit(16'h0174);
        emit(16'h43B2); emit(16'h0176);
        emit(16'h42A2); emit(16'h0178);
        emit(16'h42B2); emit(16'h017A);
        emit(16'h4036); emit(16'h0140);            // mov #0140,r6
        emit(16'h4692); emit(16'h0002); emit(16'h010C); // mov 2(r6),&010C
        emit(16'h401B); emit(16'(16'h0144 - ep * 2));   // mov sym,r11
        emit(16'h4B82); emit(16'h010E);            // mov r11,&010E
        emit(16'h421C); emit(16'h0146);            // mov &0146,r12
        emit(16'h4C86); emit(16'h0010);            // mov r12,10(r6)
        emit(16'h4C80); emit(16'(16'h0152 - ep * 2));   // mov r12,sym
        emit(16'h5292); emit(16'h0100); emit(16'h0100); // add &0100,&0100
        emit(16'h403D); emit(16'h0160);            // mov #0160,r13
        emit(16'h4D3D);                            // mov @r13+,r13
        emit(16'h4D82); emit(16'h0110);            // mov r13,&0110
        emit(16'h4030); t = 16'((ep + 2) * 2); emit(t); // mov #t,pc
        emit(16'h4339);                            // trap: mov #-1,r9
        emit(16'h3C01);                            // jmp +1
        emit(16'h4339);                            // trap
        emit(16'h4982); emit(16'h0112);            // mov r9,&0112
        emit(16'h23FF);                            // jmp to itself
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_addr == 16'h0000, "R2 reset fetch address", int'(mem_addr), 0);
        chk(!done && !mem_we, "R2 reset quiet", int'({done, mem_we}), 0);
    endtask

    task automatic t_imm_abs();
        step(2, "R1 R4 immediate");
        step(4, "R6 absolute dest");
        memchk(16'h0100, 16'h1234, "R6 absolute store");
    endtask

    task automatic t_autoinc();
        step(2, "immediate r6");
        step(2, "R4 autoinc add");
        step(4, "store r6");
        memchk(16'h0102, 16'h0122, "R8 word step");
        step(2, "R11 byte autoinc");
        step(4, "store r6");
        memchk(16'h0104, 16'h0123, "R8 byte step");
        step(4, "store r7");
        memchk(16'h0106, 16'h00AB, "R4 indirect read");
        step(1, "R3 register move");
        step(4, "store r10");
        memchk(16'h0116, 16'h1245, "R3 add result");
    endtask

    task automatic t_stack();
        step(2, "immediate sp");
        step(2, "R8 sp byte autoinc");
        step(4, "store sp");
        memchk(16'h0108, 16'h0132, "R8 sp steps by two");
    endtask

    task automatic t_consts();
        logic [15:0] exp_v [6];
        exp_v = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF, 16'h0004, 16'h0008};
        for (int k = 0; k < 6; k++) begin
            step(4, "R7 constant cost");
            memchk(16'(16'h0170 + 2 * k), exp_v[k], "R7 constant value");
        end
    endtask

    task automatic t_indexed();
        step(2, "immediate r6");
        step(6, "R5 indexed to absolute");
        memchk(16'h010C, 16'h5A5A, "R5 indexed read");
        step(3, "R5 symbolic source");
        step(4, "store r11");
        memchk(16'h010E, 16'h7777, "R5 symbolic read");
        step(3, "R5 absolute source");
        step(4, "R6 indexed dest");
        memchk(16'h0150, 16'hBEEF, "R6 indexed store");
        step(4, "R6 symbolic dest");
        memchk(16'h0152, 16'hBEEF, "R6 symbolic store");
        step(6, "R6 memory to memory");
        memchk(16'h0100, 16'h2468, "R6 read modify write");
    endtask

    task automatic t_collide();
        step(2, "immediate r13");
        step(2, "R9 autoinc onto itself");
        step(4, "store r13");
        memchk(16'h0110, 16'h3333, "R9 destination wins");
        step(2, "R9 branch by move");
        step(2, "R10 forward jump");
        step(4, "R9 R10 first after skip");
        memchk(16'h0112, 16'h0000, "R10 traps skipped");
    endtask

    task automatic t_loop();
        logic [15:0] here;
        here = 16'((ep - 1) * 2);
        step(2, "R10 backward jump");
        chk(mem_addr == here, "R10 jump target", int'(mem_addr), int'(here));
        step(2, "R10 jump repeat");
        chk(wr_cnt == 19, "R12 write count", wr_cnt, 19);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        build_program();
        t_reset();
        rst_n = 1'b1;
        t_imm_abs();
        t_autoinc();
        t_stack();
        t_consts();
        t_indexed();
        t_collide();
        t_loop();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule